// File: doc/BRIEF.md
# Alternating Two-Interval Sequencer

This block runs two timed intervals back to back, forever. Each interval is measured by its own up-counter. During the first phase counter A steps from zero to the limit `lim_a`. During the second phase counter B steps from zero to the limit `lim_b`. Then the first phase begins again. The active phase is held in a single state flip-flop. Each counter has an equality comparator against its limit, and the flag from that comparator moves the phase on.

Every counter operation is synchronous. Each counter takes a two-bit command: hold, increment, load, or decrement. A counter is cleared by loading its zero-tied data input on the edge where its own phase ends. The commands are decoded from the phase bit and the two flags. Both of those come only from registers, so the command lines settle well within the cycle.

One full cycle of the sequence takes `lim_a + lim_b + 2` clocks. The limits are expected to change only while reset is asserted.

Top module: `interval_sequencer`

## Requirements
- R1: While `rst_n` is low at a clock edge, that edge sets `phase` to 0 and both counts to 0 (synchronous active-low reset).
- R2: While `phase` is 0 and `cnt_a` differs from `lim_a`, each edge increments `cnt_a` by one, and `cnt_b` stays at 0.
- R3: While `phase` is 0 and `cnt_a` equals `lim_a`, the next edge sets `phase` to 1 and leaves both counts at 0.
- R4: While `phase` is 1 and `cnt_b` differs from `lim_b`, each edge increments `cnt_b` by one, and `cnt_a` stays at 0.
- R5: While `phase` is 1 and `cnt_b` equals `lim_b`, the next edge sets `phase` to 0 and leaves both counts at 0, so the sequence repeats with period `lim_a + lim_b + 2` cycles.
- R6: `done` is high in exactly the cycles where the active phase's count equals its limit. These are the last cycles of the phases, and `phase` toggles on the edge that follows each one.
- R7: A limit of 0 makes its phase last exactly one cycle, with `done` high in that cycle.
- R8: A limit equal to the largest W-bit value is reached without the count wrapping, so that phase lasts 2^W cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lim_a | input | W | Final count of the first phase |
| lim_b | input | W | Final count of the second phase |
| cnt_a | output | W | Counter A value |
| cnt_b | output | W | Counter B value |
| phase | output | 1 | 0 while counter A runs, 1 while counter B runs |
| done | output | 1 | High on the final count of the current phase |

## Verification
With W = 4, the bench applies every pair of limits, 256 in all, and runs each pair for two full periods after a reset. It compares every cycle against a position computed from the cycle index modulo `lim_a + lim_b + 2`. Pairs that contain a zero limit separate one-cycle phases from phases that are off by one. Pairs that contain 15 show whether the count wraps at the top of the range. Unequal pairs show whether the two limits have been swapped between the phases. The second period of each run shows whether the counters are cleared properly on each phase change.

// File: rtl/seq_pkg.sv
// Shared types for the interval sequencer.
// Assumes: counter command encoding is fixed by the counter module.
package seq_pkg;
    // Counter command: load and count bits.
    // 00 hold, 01 increment, 10 load, 11 decrement.
    typedef struct packed {
        logic load;
        logic count;
    } cnt_cmd_t;

    localparam cnt_cmd_t CMD_HOLD = '{load: 1'b0, count: 1'b0};
    localparam cnt_cmd_t CMD_INC  = '{load: 1'b0, count: 1'b1};
    localparam cnt_cmd_t CMD_LOAD = '{load: 1'b1, count: 1'b0};
endpackage

// File: rtl/ud_counter.sv
// Synchronous up/down counter with parallel load.
// Does: hold, increment, load or decrement, as selected by the command.
// Assumes: the reset is synchronous and active-low, and it clears the value.
module ud_counter
    import seq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  cnt_cmd_t     cmd,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] ONE = W'(1);

    // Update the counter value on each edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            unique case ({cmd.load, cmd.count})
                2'b00: q <= q;
                2'b01: q <= q + ONE;
                2'b10: q <= din;
                2'b11: q <= q - ONE;
            endcase
        end
    end
endmodule

// File: rtl/eq_flag.sv
// Unsigned equality comparator between a counter value and its limit.
// Assumes: both operands come from registers or from stable inputs.
module eq_flag #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         eq
);
    // Raise the flag when the operands match.
    always_comb eq = (a == b);
endmodule

// File: rtl/phase_ctrl.sv
// One-bit phase controller.
// Does: toggles the phase when the active flag is set, and decodes the two
// counter commands and the done pulse from the phase and the flags.
// Assumes: the flags are derived from registered counts and stable limits.
module phase_ctrl
    import seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flag_a,
    input  logic     flag_b,
    output logic     q,
    output cnt_cmd_t cmd_a,
    output cnt_cmd_t cmd_b,
    output logic     done
);
    logic end_now;

    // The active phase has reached its final count.
    always_comb end_now = q ? flag_b : flag_a;

    // Phase state register.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (end_now) q <= ~q;
    end

    // Mealy decode of the counter commands from the phase and the flags.
    always_comb begin
        cmd_a = CMD_HOLD;
        cmd_b = CMD_HOLD;
        if (!q) cmd_a = flag_a ? CMD_LOAD : CMD_INC;
        else    cmd_b = flag_b ? CMD_LOAD : CMD_INC;
    end

    // End-of-phase pulse.
    always_comb done = end_now;
endmodule

// File: rtl/interval_sequencer.sv
// Alternating two-interval sequencer (top).
// Does: runs counter A from 0 to lim_a, then counter B from 0 to lim_b, and repeats.
// Assumes: lim_a and lim_b change only while rst_n is low.
module interval_sequencer
    import seq_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lim_a,
    input  logic [W-1:0] lim_b,
    output logic [W-1:0] cnt_a,
    output logic [W-1:0] cnt_b,
    output logic         phase,
    output logic         done
);
    localparam int NCNT = 2;

    logic [W-1:0] cnt_v [NCNT];
    logic [W-1:0] lim_v [NCNT];
    logic         flag  [NCNT];
    cnt_cmd_t     cmd   [NCNT];

    // Gather the limits into an array for the generated lanes.
    always_comb begin
        lim_v[0] = lim_a;
        lim_v[1] = lim_b;
    end

    // One lane per counter: the counter and its comparator.
    for (genvar i = 0; i < NCNT; i++) begin : g_lane
        ud_counter #(.W(W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd   (cmd[i]),
            .din   ('0),
            .q     (cnt_v[i])
        );
        eq_flag #(.W(W)) u_eq (
            .a  (cnt_v[i]),
            .b  (lim_v[i]),
            .eq (flag[i])
        );
    end

    phase_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_a (flag[0]),
        .flag_b (flag[1]),
        .q      (phase),
        .cmd_a  (cmd[0]),
        .cmd_b  (cmd[1]),
        .done   (done)
    );

    // Drive the outputs from the lane array.
    always_comb begin
        cnt_a = cnt_v[0];
        cnt_b = cnt_v[1];
    end
endmodule

// File: rtl/interval_seq_chk.sv
// Checker for interval_sequencer: properties on the ports over time.
// Assumes: the limits stay stable while rst_n is high.
module interval_seq_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] lim_a,
    input logic [W-1:0] lim_b,
    input logic [W-1:0] cnt_a,
    input logic [W-1:0] cnt_b,
    input logic         phase,
    input logic         done
);
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (cnt_a == '0 && cnt_b == '0 && !phase));

    p_a_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && cnt_a != lim_a) |=> (!phase && cnt_a == $past(cnt_a) + W'(1)));

    p_b_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !phase |-> cnt_b == '0);

    p_to_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase && cnt_a == lim_a) |=> (phase && cnt_a == '0 && cnt_b == '0));

    p_b_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cnt_b != lim_b) |=> (phase && cnt_b == $past(cnt_b) + W'(1)));

    p_a_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        phase |-> cnt_a == '0);

    p_to_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase && cnt_b == lim_b) |=> (!phase && cnt_a == '0 && cnt_b == '0));

    p_done_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> phase != $past(phase));

    p_done_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> phase == $past(phase));
endmodule

bind interval_sequencer interval_seq_chk #(.W(W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .lim_a (lim_a),
    .lim_b (lim_b),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b),
    .phase (phase),
    .done  (done)
);

// File: tb/sim_interval_sequencer.sv
// Exhaustive sweep over all limit pairs at W = 4, with an arithmetic reference model.
module sim_interval_sequencer;
    localparam int W = 4;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] lim_a = '0;
    logic [W-1:0] lim_b = '0;
    logic [W-1:0] cnt_a;
    logic [W-1:0] cnt_b;
    logic         phase;
    logic         done;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    interval_sequencer #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .lim_a(lim_a), .lim_b(lim_b),
        .cnt_a(cnt_a), .cnt_b(cnt_b), .phase(phase), .done(done)
    );

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d: actual %0d expected %0d", tag, lim_a, lim_b, act, exp);
        end
    endtask

    // Compare the outputs with the model at position k since reset release.
    task automatic check_pos(input int n1, input int n2, input int k);
        int per;
        int m;
        int e_ph;
        int e_a;
        int e_b;
        int e_d;
        string tag;
        per = n1 + n2 + 2;
        m = k % per;
        if (m <= n1) begin
            e_ph = 0; e_a = m; e_b = 0; e_d = (m == n1);
        end else begin
            e_ph = 1; e_a = 0; e_b = m - n1 - 1; e_d = (e_b == n2);
        end
        if ((n1 == 0 && e_ph == 0) || (n2 == 0 && e_ph == 1)) tag = "R7";
        else if ((n1 == MAXV && e_ph == 0) || (n2 == MAXV && e_ph == 1)) tag = "R8";
        else if (k >= per) tag = "R5";
        else if (e_ph == 1 && m == n1 + 1) tag = "R3";
        else if (e_ph == 0) tag = "R2";
        else tag = "R4";
        check({tag, " phase"}, int'(phase), e_ph);
        check({tag, " cnt_a"}, int'(cnt_a), e_a);
        check({tag, " cnt_b"}, int'(cnt_b), e_b);
        check("R6 done", int'(done), e_d);
    endtask

    initial begin
        for (int n1 = 0; n1 <= MAXV; n1++) begin
            for (int n2 = 0; n2 <= MAXV; n2++) begin
                @(negedge clk);
                rst_n = 1'b0;
                lim_a = W'(n1);
                lim_b = W'(n2);
                @(negedge clk);
                @(negedge clk);
                check("R1 phase", int'(phase), 0);
                check("R1 cnt_a", int'(cnt_a), 0);
                check("R1 cnt_b", int'(cnt_b), 0);
                rst_n = 1'b1;
                for (int k = 0; k < 2 * (n1 + n2 + 2); k++) begin
                    check_pos(n1, n2, k);
                    @(negedge clk);
                end
            end
        end
        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule